// File: doc/BRIEF.md
# Bus Crosstalk Class Monitor

This block sits beside a parallel on-chip bus of `WIDTH` wires (at least four) and grades every pair of consecutive valid words on it. It holds the last valid word in a register. For each wire it decides whether the wire rose, fell or held. It then gives each wire a coupling factor from 0 to 4, which depends on what its two neighbours did at the same moment. The worst factor across the bus is reported alongside the per-wire factors.

It also checks four rules that crosstalk avoidance codes rely on:
- No overlap of alternating windows between consecutive words.
- No opposed transitions on adjacent wires.
- No isolated bit inside a word.
- No two same-type boundaries one wire apart inside a word.

Each rule has a per-cycle flag, a sticky flag and a saturating counter. A designer connects the monitor to a link and reads the results to learn which class of code the traffic actually meets. The monitor does not encode or decode data.

Top module: `xtalk_monitor`

## Requirements
- R1: `wireFactor` packs one 3-bit factor per wire, wire i in bits [3i+2:3i]. Wire i is bit i of `inData`. A wire whose value did not change between the two words gets factor 0.
- R2: A switching wire's factor is the sum of one term per side. A neighbour moving the same way adds 0, a steady neighbour adds 1, and a neighbour moving the opposite way adds 2. This gives 0 when both neighbours move with the wire, 1 when one moves with it and one holds, and 2 for a lone switch or for one neighbour with it and one against it. It gives 3 when one neighbour opposes and one holds, and 4 when both oppose.
- R3: Wires 0 and WIDTH-1 treat their missing neighbour as a steady line, so that side adds 1 when the edge wire switches.
- R4: `maxFactor` is the largest of the per-wire factors of the same graded word.
- R5: `ruleFlag[0]` (overlap) is set when some three adjacent wires hold 010 in the previous word and 101 in the current word, or the reverse. This happens exactly when `maxFactor` is 4.
- R6: `ruleFlag[1]` (opposition) is set when two adjacent wires switch in opposite directions.
- R7: `ruleFlag[2]` (isolated bit) is set when the current word holds 010 or 101 on any three adjacent wires.
- R8: `ruleFlag[3]` (boundary) is set when the current word holds 0101 or 1010 on any four adjacent wires, i.e. when boundaries i and i+2 are both rising or both falling.
- R9: The factors, `maxFactor` and `ruleFlag` are registered. They appear in the cycle after the edge that sampled the word, and they read all zeros after any cycle in which no word was graded.
- R10: After reset, the first valid word is not graded and only loads the previous-word register. Data offered with `inValid` low leaves that register unchanged.
- R11: `ruleSticky[k]` sets together with `ruleFlag[k]` and holds until an edge with `clearSticky` high. A new violation in the same cycle as a clear keeps the flag set.
- R12: Each rule counter adds one per graded cycle that breaks its rule. It saturates at 65535 (all ones at the default 16-bit width), is cleared only by reset, and is not affected by `clearSticky`.
- R13: While `rst` (synchronous, active high) is sampled high, all outputs, counters and the previous-word register clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clearSticky | input | 1 | Clears the sticky rule flags |
| inValid | input | 1 | Qualifies `inData` |
| inData | input | WIDTH | Bus word under observation |
| wireFactor | output | 3*WIDTH | Per-wire coupling factor of the last graded word |
| maxFactor | output | 3 | Worst coupling factor of the last graded word |
| ruleFlag | output | 4 | Per-cycle rule violations: overlap, opposition, isolated bit, boundary |
| ruleSticky | output | 4 | Sticky copies of `ruleFlag` |
| overlapCount | output | CNT_W | Overlap violation count |
| opposeCount | output | CNT_W | Opposition violation count |
| patternCount | output | CNT_W | Isolated-bit violation count |
| boundaryCount | output | CNT_W | Boundary violation count |

## Verification
Counter saturation is the hardest state to reach from the ports, because it needs 65535 offending graded cycles before the ceiling shows. The stimulus gets there by alternating the words 0x55 and 0xAA with `inValid` held high. Every such word breaks all four rules at once, so the four counters climb together to their limit, and further words must leave them there. The collision of a clear with a fresh violation is also easy to miss with random traffic alone, so a directed step puts both in the same cycle.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;

  localparam int FACTOR_W   = 3;
  localparam int RULE_COUNT = 4;

  localparam int RULE_OVERLAP  = 0;
  localparam int RULE_OPPOSE   = 1;
  localparam int RULE_PATTERN  = 2;
  localparam int RULE_BOUNDARY = 3;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'b00,
    MOVE_UP   = 2'b01,
    MOVE_DOWN = 2'b10
  } move_t;

  typedef struct packed {
    logic loadPrev;
    logic grade;
  } strobe_t;

  // Cost contributed by one side of a switching wire.
  function automatic logic [1:0] sideCost(move_t self, move_t nbr);
    if (nbr == MOVE_NONE)  return 2'd1;
    else if (nbr == self)  return 2'd0;
    else                   return 2'd2;
  endfunction

endpackage

// File: rtl/xtalk_ctrl.sv
module xtalk_ctrl
  import xtalk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobes
);

  logic havePrev;

  always_ff @(posedge clk) begin
    if (rst)          havePrev <= 1'b0;
    else if (inValid) havePrev <= 1'b1;
  end

  assign strobes.loadPrev = inValid;
  assign strobes.grade    = inValid & havePrev;

endmodule

// File: rtl/xtalk_datapath.sv
module xtalk_datapath
  import xtalk_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobe_t                   strobes,
  input  logic [WIDTH-1:0]          inData,
  output logic [WIDTH*FACTOR_W-1:0] wireFactor,
  output logic [FACTOR_W-1:0]       maxFactor,
  output logic [RULE_COUNT-1:0]     ruleFlag,
  output logic [RULE_COUNT-1:0]     ruleNow
);

  logic [WIDTH-1:0]          prevWord;
  move_t                     moves [WIDTH];
  logic [WIDTH*FACTOR_W-1:0] factorVec;
  logic [FACTOR_W-1:0]       maxNow;
  logic [RULE_COUNT-1:0]     ruleRaw;

  // Per-wire classification and factor
  for (genvar i = 0; i < WIDTH; i++) begin : g_wire
    move_t leftMove, rightMove;
    assign moves[i] = (prevWord[i] == inData[i]) ? MOVE_NONE :
                      (inData[i] ? MOVE_UP : MOVE_DOWN);
    if (i == 0) begin : g_lo_edge
      assign leftMove = MOVE_NONE;
    end else begin : g_lo_mid
      assign leftMove = moves[i-1];
    end
    if (i == WIDTH-1) begin : g_hi_edge
      assign rightMove = MOVE_NONE;
    end else begin : g_hi_mid
      assign rightMove = moves[i+1];
    end
    assign factorVec[i*FACTOR_W +: FACTOR_W] = (moves[i] == MOVE_NONE) ? '0 :
        FACTOR_W'(sideCost(moves[i], leftMove)) + FACTOR_W'(sideCost(moves[i], rightMove));
  end

  always_comb begin
    maxNow = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (factorVec[i*FACTOR_W +: FACTOR_W] > maxNow)
        maxNow = factorVec[i*FACTOR_W +: FACTOR_W];
    end
  end

  // Code-class rules
  always_comb begin
    ruleRaw = '0;
    for (int i = 1; i < WIDTH-1; i++) begin
      if ((prevWord[i-1 +: 3] == 3'b010 && inData[i-1 +: 3] == 3'b101) ||
          (prevWord[i-1 +: 3] == 3'b101 && inData[i-1 +: 3] == 3'b010))
        ruleRaw[RULE_OVERLAP] = 1'b1;
      if (inData[i-1 +: 3] == 3'b010 || inData[i-1 +: 3] == 3'b101)
        ruleRaw[RULE_PATTERN] = 1'b1;
    end
    for (int i = 0; i < WIDTH-1; i++) begin
      if ((moves[i] == MOVE_UP && moves[i+1] == MOVE_DOWN) ||
          (moves[i] == MOVE_DOWN && moves[i+1] == MOVE_UP))
        ruleRaw[RULE_OPPOSE] = 1'b1;
    end
    for (int i = 0; i < WIDTH-3; i++) begin
      if (inData[i +: 4] == 4'b0101 || inData[i +: 4] == 4'b1010)
        ruleRaw[RULE_BOUNDARY] = 1'b1;
    end
  end

  assign ruleNow = strobes.grade ? ruleRaw : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord   <= '0;
      wireFactor <= '0;
      maxFactor  <= '0;
      ruleFlag   <= '0;
    end else begin
      if (strobes.loadPrev) prevWord <= inData;
      if (strobes.grade) begin
        wireFactor <= factorVec;
        maxFactor  <= maxNow;
        ruleFlag   <= ruleRaw;
      end else begin
        wireFactor <= '0;
        maxFactor  <= '0;
        ruleFlag   <= '0;
      end
    end
  end

  assert_max_bound_R4: assert property (@(posedge clk) disable iff (rst)
    maxFactor <= FACTOR_W'(4));

  assert_overlap_matches_factor_R5: assert property (@(posedge clk) disable iff (rst)
    ruleFlag[RULE_OVERLAP] == (maxFactor == FACTOR_W'(4)));

  assert_oppose_floor_R6: assert property (@(posedge clk) disable iff (rst)
    ruleFlag[RULE_OPPOSE] |-> (maxFactor >= FACTOR_W'(2)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.grade |=> (maxFactor == '0 && ruleFlag == '0 && wireFactor == '0));

endmodule

// File: rtl/xtalk_tally.sv
module xtalk_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             clearSticky,
  output logic             sticky,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= 1'b0;
      count  <= '0;
    end else begin
      if (hit)              sticky <= 1'b1;
      else if (clearSticky) sticky <= 1'b0;
      if (hit && count != CNT_MAX) count <= count + 1'b1;
    end
  end

  assert_sticky_set_R11: assert property (@(posedge clk) disable iff (rst)
    hit |=> sticky);

  assert_count_saturate_R12: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  assert_count_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(count));

endmodule

// File: rtl/xtalk_monitor.sv
module xtalk_monitor
  import xtalk_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clearSticky,
  input  logic                      inValid,
  input  logic [WIDTH-1:0]          inData,
  output logic [WIDTH*FACTOR_W-1:0] wireFactor,
  output logic [FACTOR_W-1:0]       maxFactor,
  output logic [RULE_COUNT-1:0]     ruleFlag,
  output logic [RULE_COUNT-1:0]     ruleSticky,
  output logic [CNT_W-1:0]          overlapCount,
  output logic [CNT_W-1:0]          opposeCount,
  output logic [CNT_W-1:0]          patternCount,
  output logic [CNT_W-1:0]          boundaryCount
);

  strobe_t               strobes;
  logic [RULE_COUNT-1:0] ruleNow;
  logic [CNT_W-1:0]      ruleCount [RULE_COUNT];

  xtalk_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes)
  );

  xtalk_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .inData     (inData),
    .wireFactor (wireFactor),
    .maxFactor  (maxFactor),
    .ruleFlag   (ruleFlag),
    .ruleNow    (ruleNow)
  );

  for (genvar r = 0; r < RULE_COUNT; r++) begin : g_rule
    xtalk_tally #(.CNT_W(CNT_W)) u_tally (
      .clk         (clk),
      .rst         (rst),
      .hit         (ruleNow[r]),
      .clearSticky (clearSticky),
      .sticky      (ruleSticky[r]),
      .count       (ruleCount[r])
    );
  end

  assign overlapCount  = ruleCount[RULE_OVERLAP];
  assign opposeCount   = ruleCount[RULE_OPPOSE];
  assign patternCount  = ruleCount[RULE_PATTERN];
  assign boundaryCount = ruleCount[RULE_BOUNDARY];

endmodule

// File: tb/xtalk_monitor_tb.sv
module xtalk_monitor_tb;

  localparam int W = 8;
  localparam int CW = 16;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clearSticky = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic [3*W-1:0] wireFactor;
  logic [2:0] maxFactor;
  logic [3:0] ruleFlag, ruleSticky;
  logic [CW-1:0] overlapCount, opposeCount, patternCount, boundaryCount;

  int checks = 0;
  int errors = 0;

  bit mHave;
  logic [W-1:0] mPrev;
  logic [3:0] mSticky;
  int mCnt [4];

  always #2.5 clk = ~clk;

  xtalk_monitor #(.WIDTH(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .clearSticky(clearSticky), .inValid(inValid), .inData(inData),
    .wireFactor(wireFactor), .maxFactor(maxFactor), .ruleFlag(ruleFlag), .ruleSticky(ruleSticky),
    .overlapCount(overlapCount), .opposeCount(opposeCount),
    .patternCount(patternCount), .boundaryCount(boundaryCount)
  );

  function automatic logic [3*W-1:0] refFactors(logic [W-1:0] p, logic [W-1:0] c);
    logic [3*W-1:0] v = '0;
    for (int i = 0; i < W; i++) begin
      int f = 0;
      if (p[i] != c[i]) begin
        for (int s = 0; s < 2; s++) begin
          int j = (s == 0) ? i - 1 : i + 1;
          if (j < 0 || j >= W)       f += 1;
          else if (p[j] == c[j])     f += 1;
          else if (c[j] != c[i])     f += 2;
        end
      end
      v[3*i +: 3] = 3'(f);
    end
    return v;
  endfunction

  function automatic logic [2:0] refMax(logic [3*W-1:0] v);
    logic [2:0] m = '0;
    for (int i = 0; i < W; i++) if (v[3*i +: 3] > m) m = v[3*i +: 3];
    return m;
  endfunction

  function automatic logic [3:0] refRules(logic [W-1:0] p, logic [W-1:0] c);
    logic [3:0] r = '0;
    for (int i = 1; i < W-1; i++) begin
      if (p[i-1] != p[i] && p[i+1] != p[i] &&
          c[i-1] != p[i-1] && c[i] != p[i] && c[i+1] != p[i+1]) r[0] = 1'b1;
      if (c[i-1] != c[i] && c[i+1] != c[i]) r[2] = 1'b1;
    end
    for (int i = 0; i < W-1; i++)
      if (p[i] != c[i] && p[i+1] != c[i+1] && c[i] != c[i+1]) r[1] = 1'b1;
    for (int i = 0; i < W-3; i++)
      if (c[i] != c[i+1] && c[i+1] != c[i+2] && c[i+2] != c[i+3]) r[3] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mHave = 1'b0; mPrev = '0; mSticky = '0;
    for (int r = 0; r < 4; r++) mCnt[r] = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; clearSticky = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // Drive one word after a falling edge; check at the next falling edge.
  task automatic step(bit v, logic [W-1:0] d, bit clr, bit quiet);
    logic [3*W-1:0] ef;
    logic [3:0] er;
    inValid = v; inData = d; clearSticky = clr;
    @(negedge clk);
    ef = '0; er = '0;
    if (v && mHave) begin
      ef = refFactors(mPrev, d);
      er = refRules(mPrev, d);
    end
    for (int r = 0; r < 4; r++) begin
      mSticky[r] = er[r] | (mSticky[r] & ~clr);
      if (er[r] && mCnt[r] < CMAX) mCnt[r]++;
    end
    if (v) begin mPrev = d; mHave = 1'b1; end
    if (!quiet) begin
      chk("R2 wireFactor", 64'(wireFactor), 64'(ef));
      chk("R4 maxFactor", 64'(maxFactor), 64'(refMax(ef)));
      chk("R5 overlap flag", 64'(ruleFlag[0]), 64'(er[0]));
      chk("R6 opposition flag", 64'(ruleFlag[1]), 64'(er[1]));
      chk("R7 isolated-bit flag", 64'(ruleFlag[2]), 64'(er[2]));
      chk("R8 boundary flag", 64'(ruleFlag[3]), 64'(er[3]));
      chk("R11 sticky", 64'(ruleSticky), 64'(mSticky));
      chk("R12 overlap count", 64'(overlapCount), 64'(mCnt[0]));
      chk("R12 oppose count", 64'(opposeCount), 64'(mCnt[1]));
      chk("R12 pattern count", 64'(patternCount), 64'(mCnt[2]));
      chk("R12 boundary count", 64'(boundaryCount), 64'(mCnt[3]));
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7741));
    modelReset();
    doReset();
    // R13: reset state
    chk("R13 reset maxFactor", 64'(maxFactor), 0);
    chk("R13 reset flags", 64'({ruleFlag, ruleSticky}), 0);
    chk("R13 reset counts", 64'({overlapCount, opposeCount, patternCount, boundaryCount}), 0);

    step(1, 8'h00, 0, 0);
    chk("R10 first word not graded", 64'(maxFactor), 0);
    step(0, 8'hFF, 0, 0);
    chk("R9 idle cycle reads zero", 64'({wireFactor, maxFactor, ruleFlag}), 0);
    step(1, 8'h00, 0, 0);
    chk("R10 invalid data not loaded", 64'(wireFactor), 0);
    step(1, 8'h08, 0, 0);
    chk("R2 lone middle switch", 64'(wireFactor), 64'(24'd2 << 9)); // R1 other wires 0
    step(1, 8'h00, 0, 0);
    step(1, 8'h03, 0, 0);
    chk("R3 low edge with partner", 64'(wireFactor), 64'h9);
    step(1, 8'h83, 0, 0);
    chk("R3 high edge lone", 64'(wireFactor), 64'(24'd2 << 21));
    step(1, 8'h05, 0, 0);
    step(1, 8'h02, 0, 0);
    chk("R5 worst case factor", 64'(maxFactor), 4);
    chk("R5 overlap flag set", 64'(ruleFlag[0]), 1);
    step(1, 8'h00, 0, 0);
    step(1, 8'h00, 1, 0);
    chk("R11 sticky cleared", 64'(ruleSticky), 0);
    chk("R12 counts survive clear", 64'(overlapCount), 1);
    step(1, 8'h05, 1, 0);
    chk("R11 set wins over clear", 64'(ruleSticky[2]), 1);
    step(1, 8'h0A, 0, 0);
    chk("R8 boundary on 1010", 64'(ruleFlag[3]), 1);
    step(0, 8'h0A, 0, 0);
    chk("R9 flags drop after idle", 64'(ruleFlag), 0);

    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom % 10) < 8;
      bit c = ($urandom % 10) == 0;
      logic [W-1:0] d = W'($urandom);
      if (($urandom % 4) == 0) d = (($urandom % 2) == 0) ? (mPrev ^ W'(8'h55)) : ~mPrev;
      step(v, d, c, 0);
    end

    for (int n = 0; n < 65600; n++) step(1, (n % 2 == 0) ? 8'h55 : 8'hAA, 0, 1);
    chk("R12 overlap saturates", 64'(overlapCount), CMAX);
    chk("R12 oppose saturates", 64'(opposeCount), CMAX);
    chk("R12 pattern saturates", 64'(patternCount), CMAX);
    chk("R12 boundary saturates", 64'(boundaryCount), CMAX);
    step(1, 8'h55, 0, 0);
    step(1, 8'hAA, 0, 0);

    doReset();
    chk("R13 counts cleared by reset", 64'({overlapCount, boundaryCount}), 0);
    chk("R13 sticky cleared by reset", 64'(ruleSticky), 0);
    step(1, 8'hAA, 0, 0);
    chk("R10 first word after reset", 64'(ruleFlag), 0);
    step(1, 8'h55, 0, 0);

    finishRun();
  end

endmodule